// File: doc/BRIEF.md
# Sampling ADC Host Interface Controller

This block sits on the host side of a 14-bit sampling converter. It starts conversions and waits for the converter to finish. It then reads the result back and delivers it as a single 14-bit sample with a one-cycle valid strobe.

A conversion can be started in one of two ways:
- **Timer mode.** An internal timer with a programmable period pulses an active-low convert-start line.
- **Host mode.** The convert-start line stays high. A host request makes the block issue a chip-select plus read access, and that access itself starts the converter.

In both modes the block watches the converter's active-low busy line through a two-flop synchronizer. No result read is issued until busy has been seen asserted and then released.

The result is read in one of two ways, chosen by a mode input latched at the start of each conversion:
- **Word mode.** One 14-bit parallel read.
- **Byte mode.** Two byte reads steered by a high-byte-enable output.

The converter produces two's-complement codes. An option flips bit 13 to give straight offset binary. Two error pulses are provided:
- A watchdog reports a converter that never completes.
- A start request that arrives while the controller is already busy is dropped and reported as an overrun.

Top module: `adc_host_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, cnv_n, cs_n and rd_n are high, and sample_valid, tmo_err and ovr_err are low.
- R2: With tmr_mode high, each accepted timer tick drives cnv_n low for exactly one cycle. Ticks occur every `period` clock cycles, so accepted conversions start at whole multiples of `period` apart, and exactly `period` apart when no tick is dropped.
- R3: With tmr_mode low, a host_req pulse starts a conversion by driving cs_n and rd_n low together for RD_CYC cycles while cnv_n stays high.
- R4: No result read (cs_n and rd_n low after the start phase) begins while the converter holds busy_n low. Reads only follow a busy_n release seen through the two-flop synchronizer.
- R5: In word mode (byte_mode = 0), one read is made and the sample equals adc_bus[13:0].
- R6: In byte mode (byte_mode = 1), two reads are made. The first has hben = 0 and supplies sample[7:0] from adc_bus[7:0]. The second has hben = 1 and supplies sample[13:8] from adc_bus[5:0].
- R7: sample_valid is a one-cycle pulse. It appears exactly once per completed conversion, in the cycle after the last read.
- R8: With offset_bin = 1, sample bit 13 is the inverse of the converter's bit 13, so 0x1FFF becomes 0x3FFF and 0x2000 becomes 0x0000. With offset_bin = 0, the raw two's-complement code is passed through unchanged.
- R9: Conversions whose busy time is 19 or 20 converter clocks are both read correctly.
- R10: If busy_n is not seen both asserting and releasing within TMO_CYC (default 32) cycles after the start phase, the following happens:
  - tmo_err pulses for one cycle;
  - no sample_valid is produced for that conversion;
  - all strobes return high and the controller accepts a new start.
- R11: A start request (timer tick or host_req) that arrives while a conversion or readout is in progress is dropped. ovr_err pulses in that cycle and no extra conversion is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and converter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_mode | input | 1 | 1: timer-started conversions; 0: host-started |
| host_req | input | 1 | One-cycle start request in host mode |
| period | input | 16 | Timer period in clock cycles |
| byte_mode | input | 1 | 1: two byte reads; 0: one 14-bit read |
| offset_bin | input | 1 | 1: invert bit 13 to give offset binary |
| cnv_n | output | 1 | Active-low convert-start pulse |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| hben | output | 1 | High-byte enable during byte reads |
| adc_bus | input | 14 | Converter data bus |
| busy_n | input | 1 | Converter busy, active low, asynchronous |
| sample | output | 14 | Assembled sample |
| sample_valid | output | 1 | One-cycle strobe for sample |
| tmo_err | output | 1 | One-cycle pulse on conversion timeout |
| ovr_err | output | 1 | One-cycle pulse on a dropped start request |

## Verification
The bench drives the boundary codes 0x1FFF, 0x2000, 0x0000 and 0x3FFF through both output formats. A design that swapped byte order or steered hben backwards would return scrambled halves. One that inverted the wrong bit would miss the 0x2000/0x0000 pair.

A behavioural converter varies its busy time between 19 and 20 clocks and flags any read that begins while it is converting. This catches a controller that trusts a fixed latency or skips the synchronizer wait.

A short timer period forces ticks to land during readout. A design that queued the dropped ticks would break the start spacing, and one that ignored the overrun would not pulse ovr_err.

A converter that never releases busy, and one that never raises it, exercise the watchdog. A controller without the watchdog would hang and produce no tmo_err.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  localparam int unsigned SMP_W  = 14;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WSET,
    ST_WCLR,
    ST_RDLO,
    ST_GAP,
    ST_RDHI,
    ST_DONE
  } ctl_st_e;

endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = d_async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_comb pipe_d[g] = pipe_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/adc_period_timer.sv
module adc_period_timer #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic             tick
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W:0]   cnt_inc;
  logic             wrap;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{PER_W{1'b0}}, 1'b1};
    wrap    = en && (cnt_inc >= {1'b0, period});
    if (!en)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_inc[PER_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period > 1 && $stable(period)) |=> !tick);

endmodule

// File: rtl/adc_sample_asm.sv
module adc_sample_asm
  import adc_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_lo,
  input  logic             cap_hi,
  input  logic             byte_sel,
  input  logic             offs,
  input  logic [SMP_W-1:0] bus,
  output logic [SMP_W-1:0] sample
);

  localparam int unsigned HI_W = SMP_W - BYTE_W;

  logic [SMP_W-1:0] word_q, word_d;
  logic [SMP_W-1:0] flip;

  always_comb begin
    word_d = word_q;
    if (cap_lo) begin
      if (byte_sel) word_d[BYTE_W-1:0] = bus[BYTE_W-1:0];
      else          word_d             = bus;
    end
    if (cap_hi) word_d[SMP_W-1:BYTE_W] = bus[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                word_q <= '0;
    else if (cap_lo || cap_hi) word_q <= word_d;
  end

  always_comb begin
    flip          = '0;
    flip[SMP_W-1] = offs;
    sample        = word_q ^ flip;
  end

  // R6
  cap_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_lo && cap_hi));

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int unsigned PER_W   = 16,
  parameter int unsigned RD_CYC  = 2,
  parameter int unsigned TMO_CYC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_mode,
  input  logic             host_req,
  input  logic [PER_W-1:0] period,
  input  logic             byte_mode,
  input  logic             offset_bin,
  output logic             cnv_n,
  output logic             cs_n,
  output logic             rd_n,
  output logic             hben,
  input  logic [SMP_W-1:0] adc_bus,
  input  logic             busy_n,
  output logic [SMP_W-1:0] sample,
  output logic             sample_valid,
  output logic             tmo_err,
  output logic             ovr_err
);

  localparam int unsigned PH_W  = $clog2(RD_CYC + 1);
  localparam int unsigned TMO_W = $clog2(TMO_CYC + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[1];

  // busy line synchronizer
  logic busy_n_s, busy_s;

  adc_bit_sync #(.STAGES(2), .RST_VAL(1'b1)) u_busy_sync (
    .clk     (clk),
    .rst_n   (rst_ns),
    .d_async (busy_n),
    .q_sync  (busy_n_s)
  );
  assign busy_s = !busy_n_s;

  // timer
  logic tick;

  adc_period_timer #(.PER_W(PER_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_ns),
    .en     (tmr_mode),
    .period (period),
    .tick   (tick)
  );

  // control state machine
  ctl_st_e          st_q, st_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             bym_q, bym_d;
  logic             offs_q, offs_d;
  logic             tsrc_q, tsrc_d;
  logic             start_req, ph_last, tmo_hit;
  logic             cap_lo, cap_hi, access;

  always_comb begin
    start_req = tmr_mode ? tick : host_req;
    ph_last   = (ph_q == PH_W'(RD_CYC - 1));
    tmo_hit   = 1'b0;
    cap_lo    = 1'b0;
    cap_hi    = 1'b0;
    st_d      = st_q;
    ph_d      = ph_q;
    tmo_d     = tmo_q;
    bym_d     = bym_q;
    offs_d    = offs_q;
    tsrc_d    = tsrc_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          st_d   = ST_START;
          ph_d   = '0;
          tmo_d  = '0;
          bym_d  = byte_mode;
          offs_d = offset_bin;
          tsrc_d = tmr_mode;
        end
      end
      ST_START: begin
        if (tsrc_q || ph_last) begin
          st_d = ST_WSET;
          ph_d = '0;
        end else begin
          ph_d = ph_q + PH_W'(1);
        end
      end
      ST_WSET: begin
        tmo_hit = (tmo_q == TMO_W'(TMO_CYC - 1));
        if (tmo_hit)     st_d = ST_IDLE;
        else begin
          tmo_d = tmo_q + TMO_W'(1);
          if (busy_s)    st_d = ST_WCLR;
        end
      end
      ST_WCLR: begin
        tmo_hit = (tmo_q == TMO_W'(TMO_CYC - 1));
        if (tmo_hit)     st_d = ST_IDLE;
        else begin
          tmo_d = tmo_q + TMO_W'(1);
          if (!busy_s) begin
            st_d = ST_RDLO;
            ph_d = '0;
          end
        end
      end
      ST_RDLO: begin
        if (ph_last) begin
          cap_lo = 1'b1;
          ph_d   = '0;
          st_d   = bym_q ? ST_GAP : ST_DONE;
        end else begin
          ph_d = ph_q + PH_W'(1);
        end
      end
      ST_GAP: st_d = ST_RDHI;
      ST_RDHI: begin
        if (ph_last) begin
          cap_hi = 1'b1;
          ph_d   = '0;
          st_d   = ST_DONE;
        end else begin
          ph_d = ph_q + PH_W'(1);
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      tmo_q  <= '0;
      bym_q  <= 1'b0;
      offs_q <= 1'b0;
      tsrc_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      tmo_q  <= tmo_d;
      bym_q  <= bym_d;
      offs_q <= offs_d;
      tsrc_q <= tsrc_d;
    end
  end

  // converter-side strobes
  always_comb begin
    access = ((st_q == ST_START) && !tsrc_q) || (st_q == ST_RDLO) || (st_q == ST_RDHI);
    cnv_n  = !((st_q == ST_START) && tsrc_q);
    cs_n   = !access;
    rd_n   = !access;
    hben   = (st_q == ST_RDHI);
  end

  adc_sample_asm u_asm (
    .clk      (clk),
    .rst_n    (rst_ns),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .byte_sel (bym_q),
    .offs     (offs_q),
    .bus      (adc_bus),
    .sample   (sample)
  );

  assign sample_valid = (st_q == ST_DONE);
  assign tmo_err      = tmo_hit;
  assign ovr_err      = start_req && (st_q != ST_IDLE);

  // R2
  cnv_single_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !cnv_n |=> cnv_n);

  // R3
  cs_excl_cnv_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !cs_n |-> cnv_n);

  // R4
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!rd_n && st_q != ST_START) |-> !busy_s);

  // R6
  hben_read_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    hben |-> (!rd_n && !cs_n && bym_q));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    sample_valid |=> !sample_valid);

  // R10
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    tmo_err |=> (cnv_n && cs_n && rd_n && !sample_valid));

  // R11
  ovr_drop_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ovr_err |=> !(st_q == ST_START && $past(st_q) != ST_START));

endmodule

// File: tb/adc_host_ctrl_tb.sv
module adc_host_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tmr_mode, host_req, byte_mode, offset_bin;
  logic [15:0] period;
  logic        cnv_n, cs_n, rd_n, hben;
  logic [13:0] adc_bus;
  logic        busy_n;
  logic [13:0] sample;
  logic        sample_valid, tmo_err, ovr_err;

  always #2 clk = ~clk;

  adc_host_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_mode(tmr_mode), .host_req(host_req),
    .period(period), .byte_mode(byte_mode), .offset_bin(offset_bin),
    .cnv_n(cnv_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
    .adc_bus(adc_bus), .busy_n(busy_n), .sample(sample),
    .sample_valid(sample_valid), .tmo_err(tmo_err), .ovr_err(ovr_err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] exp_sample(input logic [13:0] code, input logic offs);
    return offs ? (code ^ 14'h2000) : code;
  endfunction

  // behavioural converter
  logic        conv, pend, acc_prev, hben_prev, cnv_prev;
  logic [13:0] res;
  int          cnt;
  logic        stuck, dead, mdl_clear, use_next, force19, force20;
  logic [13:0] next_code;
  int          viol = 0;
  logic [13:0] exp_q[$];
  wire         acc = !cs_n && !rd_n;

  assign adc_bus = !acc ? 14'h0 :
                   !byte_mode ? res :
                   hben ? {8'h00, 2'b00, res[13:8]} : {6'h00, res[7:0]};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv <= 1'b0; pend <= 1'b0; acc_prev <= 1'b0; hben_prev <= 1'b0;
      cnv_prev <= 1'b1; busy_n <= 1'b1; cnt <= 0; res <= '0;
    end else begin
      logic st;
      logic [13:0] c;
      acc_prev  <= acc;
      hben_prev <= hben;
      cnv_prev  <= cnv_n;
      if (acc && !acc_prev && conv) viol <= viol + 1;
      st = tmr_mode ? (!cnv_n && cnv_prev) : (acc && !acc_prev && !conv && !pend);
      if (mdl_clear) begin
        conv <= 1'b0; pend <= 1'b0; busy_n <= 1'b1;
      end else if (st && !dead) begin
        c = use_next ? next_code : 14'($urandom);
        res <= c;
        exp_q.push_back(c);
        conv   <= 1'b1;
        busy_n <= 1'b0;
        cnt    <= force19 ? 19 : force20 ? 20 : (($urandom & 1) != 0 ? 20 : 19);
      end else if (conv) begin
        if (cnt <= 1) begin
          if (!stuck) begin
            conv <= 1'b0; pend <= 1'b1; busy_n <= 1'b1;
          end
        end else cnt <= cnt - 1;
      end else if (acc_prev && !acc && pend && (!byte_mode || hben_prev)) begin
        pend <= 1'b0;
      end
    end
  end

  // monitors
  int valid_cnt = 0, tmo_cnt = 0, ovr_cnt = 0, nf = 0;
  int fall_t[64];
  logic cnv_seen_prev = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_valid) begin
        valid_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R7", 1, 0);
        else begin
          logic [13:0] e;
          e = exp_sample(exp_q.pop_front(), offset_bin);
          check(sample == e, byte_mode ? "R6 R8 R9" : "R5 R8 R9", sample, e);
        end
      end
      if (tmo_err) tmo_cnt++;
      if (ovr_err) ovr_cnt++;
      if (!cnv_n && cnv_seen_prev && nf < 64) begin
        fall_t[nf] = cyc;
        nf++;
      end
      cnv_seen_prev = cnv_n;
    end
  end

  task automatic wait_valid(input int target);
    for (int i = 0; i < 400 && valid_cnt < target; i++) @(negedge clk);
  endtask

  task automatic host_conv(input bit dir, input logic [13:0] code);
    int tgt;
    tgt = valid_cnt + 1;
    @(negedge clk);
    use_next = dir; next_code = code;
    host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    wait_valid(tgt);
    check(valid_cnt == tgt, "R7", valid_cnt, tgt);
    repeat (3) @(negedge clk);
  endtask

  task automatic timeout_case(input bit never_start);
    int t0, v0;
    t0 = tmo_cnt; v0 = valid_cnt;
    stuck = !never_start; dead = never_start;
    @(negedge clk); host_req = 1'b1;
    @(negedge clk); host_req = 1'b0;
    for (int i = 0; i < 100 && tmo_cnt == t0; i++) @(negedge clk);
    check(tmo_cnt == t0 + 1, "R10", tmo_cnt, t0 + 1);
    check(cnv_n && cs_n && rd_n, "R10", {cnv_n, cs_n, rd_n}, 3'b111);
    if (!never_start) void'(exp_q.pop_front());
    stuck = 1'b0; dead = 1'b0;
    mdl_clear = 1'b1; @(negedge clk); mdl_clear = 1'b0;
    repeat (10) @(negedge clk);
    check(valid_cnt == v0, "R10", valid_cnt, v0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    int s, v0, o0, n0;
    s = $urandom(32'h5eed);
    rst_n = 1'b0; tmr_mode = 1'b0; host_req = 1'b0; byte_mode = 1'b0;
    offset_bin = 1'b0; period = 16'd64; stuck = 1'b0; dead = 1'b0;
    mdl_clear = 1'b0; use_next = 1'b0; next_code = '0; force19 = 1'b0; force20 = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(cnv_n && cs_n && rd_n, "R1", {cnv_n, cs_n, rd_n}, 3'b111);
    check(!sample_valid && !tmo_err && !ovr_err, "R1",
          {sample_valid, tmo_err, ovr_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cnv_n && cs_n && rd_n && !sample_valid, "R1", {cnv_n, cs_n, rd_n}, 3'b111);

    // R3: host start access shape
    @(negedge clk); host_req = 1'b1;
    @(negedge clk); host_req = 1'b0;
    check(!cs_n && !rd_n && cnv_n, "R3", {cnv_n, cs_n, rd_n}, 3'b100);
    @(negedge clk);
    check(!cs_n && !rd_n && cnv_n, "R3", {cnv_n, cs_n, rd_n}, 3'b100);
    wait_valid(1);
    repeat (3) @(negedge clk);

    // R5 R8 R9 directed corners, word mode
    force19 = 1'b1;
    host_conv(1'b1, 14'h1FFF);
    host_conv(1'b1, 14'h2000);
    force19 = 1'b0; force20 = 1'b1;
    offset_bin = 1'b1;
    host_conv(1'b1, 14'h1FFF);
    host_conv(1'b1, 14'h2000);
    force20 = 1'b0;
    offset_bin = 1'b0;
    for (int i = 0; i < 8; i++) host_conv(1'b0, '0);

    // R6 byte mode corners and random
    byte_mode = 1'b1;
    host_conv(1'b1, 14'h3FFF);
    host_conv(1'b1, 14'h0000);
    host_conv(1'b1, 14'h2A55);
    offset_bin = 1'b1;
    host_conv(1'b1, 14'h2000);
    for (int i = 0; i < 8; i++) host_conv(1'b0, '0);
    use_next = 1'b0;

    // R11 host overrun
    o0 = ovr_cnt; v0 = valid_cnt; n0 = exp_q.size();
    @(negedge clk); host_req = 1'b1;
    @(negedge clk); host_req = 1'b0;
    repeat (8) @(negedge clk);
    host_req = 1'b1; @(negedge clk); host_req = 1'b0;
    wait_valid(v0 + 1);
    repeat (60) @(negedge clk);
    check(ovr_cnt == o0 + 1, "R11", ovr_cnt, o0 + 1);
    check(valid_cnt == v0 + 1, "R11", valid_cnt, v0 + 1);
    check(exp_q.size() == n0, "R11", exp_q.size(), n0);

    // R10 timeouts
    byte_mode = 1'b0; offset_bin = 1'b0;
    timeout_case(1'b0);
    timeout_case(1'b1);
    host_conv(1'b0, '0);

    // R2 timer mode, no drops
    nf = 0; period = 16'd64; byte_mode = 1'b1;
    v0 = valid_cnt;
    tmr_mode = 1'b1;
    wait_valid(v0 + 6);
    for (int i = 0; i < 400 && nf < 6; i++) @(negedge clk);
    tmr_mode = 1'b0;
    repeat (80) @(negedge clk);
    for (int i = 1; i < nf; i++)
      check(fall_t[i] - fall_t[i-1] == 64, "R2", fall_t[i] - fall_t[i-1], 64);

    // R11 R2 timer overrun with short period
    nf = 0; period = 16'd12; byte_mode = 1'b0; offset_bin = 1'b1;
    o0 = ovr_cnt; v0 = valid_cnt;
    tmr_mode = 1'b1;
    wait_valid(v0 + 5);
    tmr_mode = 1'b0;
    repeat (80) @(negedge clk);
    check(ovr_cnt > o0, "R11", ovr_cnt - o0, 1);
    for (int i = 1; i < nf; i++)
      check((fall_t[i] - fall_t[i-1]) % 12 == 0 && fall_t[i] > fall_t[i-1], "R2",
            fall_t[i] - fall_t[i-1], 12);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);

    // R4 read never started during conversion
    check(viol == 0, "R4", viol, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule